// File: doc/BRIEF.md
# Image Sensor Row Readout Sequencer

This block drives the controller side of a row-by-row readout handshake with an image sensor. When a frame scan is started, it visits every line between a first and a last line number, inclusive. For each line it does four things in turn:

- puts the 10-bit line number on the address bus;
- pulls an active-low start strobe low for a fixed number of clocks;
- waits for the sensor's active-low completion pulse;
- steps to the next line.

For each line, the sensor reads the addressed row, digitizes it into 10-bit samples and stores them in its 1280-entry column register. The sensor answers 128 or 129 clocks after the strobe falls, because its row logic runs at half the system clock. Unloading the column data is outside this block.

The completion pulse is asynchronous to the block. It passes through a two-flop synchronizer, and only its falling edge is used, so the two-clock-wide pulse counts once. The block signals each finished line with a one-cycle event and the end of a frame with a flag. A line that gets no answer ends the scan with a timeout error.

Top module: `lrs_seq`

## Requirements
- R1: While reset is held and after it is released, line_strobe_n is 1, line_done, frame_done and scan_timeout are 0 and line_addr is 0.
- R2: A scan_go seen while idle loads first_line onto line_addr in the next cycle, while line_strobe_n is still 1. line_strobe_n first goes low two cycles after the cycle in which scan_go was high.
- R3: line_strobe_n stays low for exactly STROBE_W consecutive cycles (STROBE_W in 2..100, default 2), and line_addr does not change while it is low.
- R4: sens_ack_n is synchronized by two flops and only its falling edge counts. line_done is high for exactly one cycle, three cycles after the cycle in which sens_ack_n first reads low, and a two-cycle-wide low pulse produces one line_done.
- R5: line_addr holds each line for at least HOLD_MIN (66) cycles. This count starts with the cycle before the strobe falls. A completion that arrives early is kept pending, and line_done is then raised 65 cycles after the strobe fell.
- R6: line_addr shows the next line in the same cycle that line_done is high, and the strobe for that line falls in the following cycle.
- R7: Lines step by +1 when last_line >= first_line, otherwise by -1, and both end lines are included. frame_done is high together with the line_done of the last line, and the block then stays idle with line_strobe_n high.
- R8: A completion that falls 128 or 129 cycles after the strobe falls is accepted.
- R9: If no completion edge has been accepted by 140 cycles after the strobe fell, scan_timeout rises in that 140th cycle, line_strobe_n stays high and the block goes idle. scan_timeout stays high until the next accepted scan_go, which clears it in the cycle after.
- R10: A completion whose edge is detected in the last cycle before expiry (sens_ack_n low 137 cycles after the strobe fell) wins over the timeout: line_done is raised and scan_timeout stays low.
- R11: scan_go, first_line and last_line are ignored while a scan is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_go | input | 1 | Start a frame scan (taken only while idle) |
| first_line | input | 10 | First line to read |
| last_line | input | 10 | Last line to read |
| sens_ack_n | input | 1 | Active-low completion pulse from the sensor |
| line_addr | output | 10 | Line number driven to the sensor |
| line_strobe_n | output | 1 | Active-low line start strobe |
| line_done | output | 1 | One-cycle event per completed line |
| frame_done | output | 1 | One-cycle flag with the last line's completion |
| scan_timeout | output | 1 | Completion missing; held until the next scan start |

## Verification
Two events can fall in the same cycle: an accepted completion edge and the expiry of the response window. To provoke the collision, the sensor model is told to answer 137 cycles after the strobe falls, which puts the synchronized edge into the last counted cycle. One cycle later (138) the same answer must lose to the timeout. The bench predicts from R9 and R10 which of line_done and scan_timeout appears, and in exactly which cycle, and it compares both outputs. Random frames with answers of 128 or 129 cycles, early answers, silent sensors and scan starts during a running scan surround these two cases.

// File: rtl/lrs_pkg.sv
// Package lrs_pkg
// Shared type for the line readout sequencer: the controller state encoding.
// Assumes: nothing beyond standard SystemVerilog packages.
package lrs_pkg;

    // Controller phases of one line visit
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // waiting for a scan start
        ST_SETUP  = 2'd1,   // address driven, strobe still high
        ST_STROBE = 2'd2,   // strobe held low
        ST_WAIT   = 2'd3    // strobe released, waiting for completion
    } seq_state_t;

endpackage

// File: rtl/lrs_sync.sv
// Module lrs_sync
// Brings the sensor's active-low completion into the clock domain and flags
// its falling edge for one cycle.
// Assumes: input idles high; STAGES >= 2. Reset loads all flops high so that
// no edge is reported when reset is released.
module lrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    output logic fall_o
);

    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    // Shift the raw input through the synchronizer and history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '1;
        end else begin
            sh <= {sh[STAGES-1:0], ack_n_i};
        end
    end

    // Falling edge of the synchronized level
    always_comb begin
        fall_o = sh[STAGES] & ~sh[STAGES-1];
    end

endmodule

// File: rtl/lrs_timer.sv
// Module lrs_timer
// One cycle counter for a whole line visit. It times the strobe width, the
// minimum address hold and the completion window.
// Assumes: clear_i and run_i are never high together; the counter saturates
// at its top value instead of wrapping.
module lrs_timer #(
    parameter int STROBE_W    = 2,
    parameter int ADV_MIN     = 64,
    parameter int TIMEOUT_CYC = 140,
    parameter int CNT_W       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic strobe_end_o,
    output logic hold_met_o,
    output logic expire_o
);

    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_W - 1);
    localparam logic [CNT_W-1:0] ADV_LIM     = CNT_W'(ADV_MIN);
    localparam logic [CNT_W-1:0] EXP_LAST    = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_TOP     = '1;

    logic [CNT_W-1:0] cnt_q;

    // Count cycles since the strobe fell; clear before each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Window decodes used by the controller
    always_comb begin
        strobe_end_o = (cnt_q == STROBE_LAST);
        hold_met_o   = (cnt_q >= ADV_LIM);
        expire_o     = (cnt_q == EXP_LAST);
    end

endmodule

// File: rtl/lrs_addr.sv
// Module lrs_addr
// Holds the current line number, the end line and the step direction.
// Assumes: load_i and step_i are never high together; step_i is only raised
// when the current line is not the end line.
module lrs_addr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] first_i,
    input  logic [AW-1:0] last_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          is_last_o
);

    logic [AW-1:0] cur_q;
    logic [AW-1:0] end_q;
    logic          up_q;

    // Capture the scan bounds at start, then move one line per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            end_q <= '0;
            up_q  <= 1'b1;
        end else if (load_i) begin
            cur_q <= first_i;
            end_q <= last_i;
            up_q  <= (last_i >= first_i);
        end else if (step_i) begin
            cur_q <= up_q ? cur_q + 1'b1 : cur_q - 1'b1;
        end
    end

    // Current line and end-of-scan detection
    always_comb begin
        addr_o    = cur_q;
        is_last_o = (cur_q == end_q);
    end

endmodule

// File: rtl/lrs_fsm.sv
// Module lrs_fsm
// Sequences one scan: setup cycle, strobe, wait for completion, then advance,
// finish or give up on timeout. Owns the registered handshake outputs.
// Assumes: fall_i is a one-cycle synchronized edge; timer decodes refer to the
// cycle count since the strobe fell.
module lrs_fsm
    import lrs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic fall_i,
    input  logic strobe_end_i,
    input  logic hold_met_i,
    input  logic expire_i,
    input  logic is_last_i,
    output logic load_o,
    output logic step_o,
    output logic clear_o,
    output logic run_o,
    output logic strobe_n_o,
    output logic line_done_o,
    output logic frame_done_o,
    output logic timeout_o
);

    seq_state_t state_q;
    logic       pend_q;
    logic       strobe_n_q;
    logic       done_q;
    logic       fdone_q;
    logic       err_q;
    logic       adv;
    logic       give_up;

    // Decide advance and timeout for the current cycle; completion has priority
    always_comb begin
        adv     = (state_q == ST_WAIT) && (fall_i || pend_q) && hold_met_i;
        give_up = (state_q == ST_WAIT) && !adv && expire_i;
        load_o  = (state_q == ST_IDLE) && go_i;
        step_o  = adv && !is_last_i;
        clear_o = (state_q == ST_SETUP);
        run_o   = (state_q == ST_STROBE) || (state_q == ST_WAIT);
    end

    // State, pending completion and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_q     <= 1'b0;
            strobe_n_q <= 1'b1;
            done_q     <= 1'b0;
            fdone_q    <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            fdone_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    pend_q <= 1'b0;
                    if (go_i) begin
                        err_q   <= 1'b0;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    pend_q     <= 1'b0;
                    strobe_n_q <= 1'b0;
                    state_q    <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (fall_i) begin
                        pend_q <= 1'b1;
                    end
                    if (strobe_end_i) begin
                        strobe_n_q <= 1'b1;
                        state_q    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (adv) begin
                        pend_q <= 1'b0;
                        done_q <= 1'b1;
                        if (is_last_i) begin
                            fdone_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_SETUP;
                        end
                    end else if (give_up) begin
                        pend_q  <= 1'b0;
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (fall_i) begin
                        pend_q <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive registered outputs
    always_comb begin
        strobe_n_o   = strobe_n_q;
        line_done_o  = done_q;
        frame_done_o = fdone_q;
        timeout_o    = err_q;
    end

endmodule

// File: rtl/lrs_seq.sv
// Module lrs_seq (top)
// Line-by-line readout sequencer for an image sensor. Drives line number and
// active-low start strobe, waits for the sensor's active-low completion pulse,
// and reports per-line completion, end of frame and missing responses.
// Assumes: sens_ack_n is asynchronous and idles high; STROBE_W is 2..100;
// HOLD_MIN counts from the setup cycle before the strobe falls.
module lrs_seq #(
    parameter int AW          = 10,
    parameter int STROBE_W    = 2,
    parameter int HOLD_MIN    = 66,
    parameter int TIMEOUT_CYC = 140,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_go,
    input  logic [AW-1:0] first_line,
    input  logic [AW-1:0] last_line,
    input  logic          sens_ack_n,
    output logic [AW-1:0] line_addr,
    output logic          line_strobe_n,
    output logic          line_done,
    output logic          frame_done,
    output logic          scan_timeout
);

    // Address is visible one setup cycle before the strobe and one cycle
    // after the advance decision, hence the offset of two.
    localparam int ADV_MIN = HOLD_MIN - 2;
    localparam int CNT_W   = $clog2(TIMEOUT_CYC + 1);

    logic fall;
    logic strobe_end;
    logic hold_met;
    logic expire;
    logic is_last;
    logic load;
    logic step;
    logic clr;
    logic run;

    lrs_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_n_i (sens_ack_n),
        .fall_o  (fall)
    );

    lrs_timer #(
        .STROBE_W    (STROBE_W),
        .ADV_MIN     (ADV_MIN),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clr),
        .run_i        (run),
        .strobe_end_o (strobe_end),
        .hold_met_o   (hold_met),
        .expire_o     (expire)
    );

    lrs_addr #(
        .AW (AW)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .first_i   (first_line),
        .last_i    (last_line),
        .step_i    (step),
        .addr_o    (line_addr),
        .is_last_o (is_last)
    );

    lrs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (scan_go),
        .fall_i       (fall),
        .strobe_end_i (strobe_end),
        .hold_met_i   (hold_met),
        .expire_i     (expire),
        .is_last_i    (is_last),
        .load_o       (load),
        .step_o       (step),
        .clear_o      (clr),
        .run_o        (run),
        .strobe_n_o   (line_strobe_n),
        .line_done_o  (line_done),
        .frame_done_o (frame_done),
        .timeout_o    (scan_timeout)
    );

endmodule

// File: rtl/lrs_chk.sv
// Module lrs_chk
// Protocol checker for lrs_seq, attached by bind. Watches only the top ports.
// Assumes: synchronous active-low reset asserted from time zero.
module lrs_chk #(
    parameter int AW       = 10,
    parameter int STROBE_W = 2,
    parameter int HOLD_MIN = 66
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] line_addr,
    input logic          line_strobe_n,
    input logic          line_done,
    input logic          frame_done,
    input logic          scan_timeout
);

    logic [7:0]    low_cnt;
    logic [7:0]    hold_cnt;
    logic [AW-1:0] prev_addr;
    logic          strobed;
    logic          addr_moved;

    always_comb begin
        addr_moved = (line_addr != prev_addr);
    end

    // Track strobe-low run length, address age and whether a strobe was seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            hold_cnt  <= '0;
            prev_addr <= '0;
            strobed   <= 1'b0;
        end else begin
            low_cnt   <= line_strobe_n ? 8'd0 : ((low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1);
            hold_cnt  <= addr_moved ? 8'd1 : ((hold_cnt == 8'hFF) ? hold_cnt : hold_cnt + 8'd1);
            prev_addr <= line_addr;
            strobed   <= addr_moved ? 1'b0 : (strobed | ~line_strobe_n);
        end
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_strobe_n) |-> (low_cnt == 8'(STROBE_W))); // R3

    AST_STROBE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_strobe_n && !$past(line_strobe_n)) |-> $stable(line_addr)); // R3

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_moved && strobed) |-> (hold_cnt >= 8'(HOLD_MIN))); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done); // R4

    AST_NEXT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done && !frame_done) |=> !line_strobe_n); // R6

    AST_FRAME_WITH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> line_done); // R7

    AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_timeout) |-> (!line_done && line_strobe_n)); // R9

endmodule

bind lrs_seq lrs_chk #(
    .AW       (AW),
    .STROBE_W (STROBE_W),
    .HOLD_MIN (HOLD_MIN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_addr     (line_addr),
    .line_strobe_n (line_strobe_n),
    .line_done     (line_done),
    .frame_done    (frame_done),
    .scan_timeout  (scan_timeout)
);

// File: tb/lrs_seq_tb.sv
// Bench lrs_seq_tb
// Drives scans of the sequencer against a sensor model whose answer delay is
// chosen per line, and checks every handshake event at a predicted cycle.
// All observation and driving happen at the falling clock edge in one thread.
module lrs_seq_tb;

    localparam int SW       = 2;
    localparam int ADV      = 64;
    localparam int WIN      = 140;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_go = 1'b0;
    logic [9:0] first_line = '0;
    logic [9:0] last_line = '0;
    logic       sens_ack_n = 1'b1;
    logic [9:0] line_addr;
    logic       line_strobe_n;
    logic       line_done;
    logic       frame_done;
    logic       scan_timeout;

    always #10 clk = ~clk;

    lrs_seq #(
        .STROBE_W (SW)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scan_go       (scan_go),
        .first_line    (first_line),
        .last_line     (last_line),
        .sens_ack_n    (sens_ack_n),
        .line_addr     (line_addr),
        .line_strobe_n (line_strobe_n),
        .line_done     (line_done),
        .frame_done    (frame_done),
        .scan_timeout  (scan_timeout)
    );

    int    vectors = 0;
    int    fails = 0;
    int    cyc = 0;
    int    s_cyc = -1000;
    int    d_cur = 0;
    int    exp_done = -1;
    int    exp_to = -1;
    int    g_cyc = 0;
    int    last_done = 0;
    int    exp_addr = 0;
    int    fr_last = 0;
    int    fr_step = 1;
    int    cfg_d = 0;
    int    low_cnt = 0;
    int    seed_dummy;
    bit    mute = 1'b0;
    bit    sens_on = 1'b0;
    bit    frame_open = 1'b0;
    bit    first_pend = 1'b0;
    bit    prev_go_n = 1'b1;
    bit    prev_err = 1'b0;
    string cfg_tag = "R4";

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected line_done cycle for a strobe falling at s with answer delay d
    function automatic int done_at(input int s, input int d);
        return s + mx(mx(d + 2, ADV), SW) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // One cycle: observe outputs, predict, then drive the sensor model
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, WATCHDOG);
            finish_run();
        end
        if (prev_go_n && !line_strobe_n) begin
            if (first_pend) check(cyc == g_cyc + 2, "R2", cyc, g_cyc + 2);
            else            check(cyc == last_done + 1, "R6", cyc, last_done + 1);
            first_pend = 1'b0;
            check(int'(line_addr) == exp_addr, "R7", int'(line_addr), exp_addr);
            s_cyc   = cyc;
            d_cur   = (cfg_d == 0) ? 128 + int'($urandom_range(0, 1)) : cfg_d;
            sens_on = !mute;
            if (mute || d_cur >= WIN - 2) begin
                exp_to   = cyc + WIN;
                exp_done = -1;
            end else begin
                exp_done = done_at(cyc, d_cur);
                exp_to   = -1;
            end
            low_cnt = 0;
        end
        if (!line_strobe_n) low_cnt++;
        if (!prev_go_n && line_strobe_n) begin
            check(low_cnt == SW, "R3", low_cnt, SW);
            check(int'(line_addr) == exp_addr, "R3", int'(line_addr), exp_addr);
        end
        if (line_done || cyc == exp_done) begin
            check(line_done && cyc == exp_done, cfg_tag, line_done ? cyc : -1, exp_done);
            if (line_done) begin
                check(frame_done == (exp_addr == fr_last), "R7", int'(frame_done), int'(exp_addr == fr_last));
                if (exp_addr != fr_last) exp_addr += fr_step;
                else                     frame_open = 1'b0;
                check(int'(line_addr) == exp_addr, "R6", int'(line_addr), exp_addr);
                last_done = cyc;
            end
        end else if (frame_done) begin
            check(1'b0, "R7", 1, 0);
        end
        if ((scan_timeout && !prev_err) || cyc == exp_to) begin
            check(scan_timeout && !prev_err && cyc == exp_to && line_strobe_n, "R9",
                  scan_timeout ? cyc : -1, exp_to);
            if (scan_timeout) frame_open = 1'b0;
        end
        sens_ack_n = !(sens_on && (cyc == s_cyc + d_cur || cyc == s_cyc + d_cur + 1));
        prev_go_n  = line_strobe_n;
        prev_err   = scan_timeout;
    endtask

    // Run one scan; poke=1 issues a scan_go with other bounds mid-scan
    task automatic run_frame(input int first, input int last, input int d,
                             input bit mute_in, input string tag, input bit poke);
        cfg_d      = d;
        mute       = mute_in;
        cfg_tag    = tag;
        fr_last    = last;
        fr_step    = (last >= first) ? 1 : -1;
        exp_addr   = first;
        first_line = 10'(first);
        last_line  = 10'(last);
        scan_go    = 1'b1;
        g_cyc      = cyc;
        first_pend = 1'b1;
        frame_open = 1'b1;
        tick();
        scan_go = 1'b0;
        check(int'(line_addr) == first && line_strobe_n, "R2", int'(line_addr), first);
        check(!scan_timeout, "R9", int'(scan_timeout), 0);
        while (frame_open) begin
            tick();
            if (poke && cyc == g_cyc + 60) begin
                scan_go    = 1'b1;
                first_line = ~10'(first);
                last_line  = ~10'(last);
            end else if (scan_go) begin
                scan_go    = 1'b0;
                first_line = 10'(first);
                last_line  = 10'(last);
                check(int'(line_addr) == exp_addr && !line_strobe_n == 1'b0, "R11",
                      int'(line_addr), exp_addr);
            end
        end
        for (int i = 0; i < 14; i++) tick();
        check(line_strobe_n && !line_done, "R7", int'(line_strobe_n), 1);
    endtask

    initial begin
        seed_dummy = $urandom(32'd2024);
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        check(line_strobe_n && !line_done && !frame_done && !scan_timeout && line_addr == '0,
              "R1", int'(line_addr), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        check(line_strobe_n && !line_done && !frame_done && !scan_timeout && line_addr == '0,
              "R1", int'(line_strobe_n), 1);

        // Directed corner cases
        run_frame(0, 2, 128, 1'b0, "R8", 1'b0);        // R8 fixed 128, ascending
        run_frame(1023, 1021, 129, 1'b0, "R8", 1'b0);  // R8 fixed 129, descending top end
        run_frame(500, 500, 0, 1'b0, "R4", 1'b0);      // R7 single line
        run_frame(40, 42, 20, 1'b0, "R5", 1'b0);       // R5 early answer deferred
        run_frame(7, 8, 137, 1'b0, "R10", 1'b0);       // R10 completion beats expiry
        run_frame(9, 12, 138, 1'b0, "R9", 1'b0);       // R9 one cycle too late
        run_frame(300, 303, 0, 1'b1, "R9", 1'b0);      // R9 silent sensor
        run_frame(100, 103, 0, 1'b0, "R11", 1'b1);     // R11 scan_go while busy

        // Constrained random scans
        for (int k = 0; k < 8; k++) begin
            int f;
            int l;
            f = int'($urandom_range(0, 1023));
            l = f + int'($urandom_range(0, 6)) - 3;
            if (l < 0) l = 0;
            if (l > 1023) l = 1023;
            run_frame(f, l, 0, 1'b0, "R4", 1'b0);
        end
        finish_run();
    end

endmodule